// File: doc/BRIEF.md
# Winner Activation Selector

This block sits beside the neuron array of one parent chunk in a layered sequence-memory engine. Whenever the array finishes an update step it raises a strobe. The selector then compares the activities of all neurons in the chunk and takes the most active one as the winner for that step. It keeps the winner's index in a register. It drives one activation line per child chunk, with exactly the winner's line high. Each activation line is the enable for the clock gate of one child chunk, so only the child that belongs to the current winner advances its own dynamics.

The winner is chosen again at every accepted step. A change of winner moves the single active line from one child to the next, and the selector raises a one-cycle pulse to mark that handover. While the parent chunk is not activated itself, the selector ignores step strobes and holds every activation line low. Activities are unsigned integers packed into one flat vector. Neuron `i` occupies bits `[i*ACT_W +: ACT_W]`.

Top module: `wsel_top`

## Requirements
- R1: On a clock edge where `step_done` and `parent_active` are both high (an accepted step), the selector takes as the new winner the neuron with the largest unsigned activity. Neuron `i` is read from `activity[i*ACT_W +: ACT_W]`. `winner_idx` shows the new winner from the next cycle on.
- R2: When several neurons share the largest activity, the one with the lowest index wins.
- R3: `winner_idx` changes only at the edge of an accepted step. In every other cycle it holds its value.
- R4: A `step_done` strobe that arrives while `parent_active` is low has no effect. `winner_idx` stays unchanged and no `winner_changed` pulse follows.
- R5: While `parent_active` was high at the previous edge and at least one step has been accepted since reset, `child_en` is one-hot and bit `winner_idx` is the bit that is set.
- R6: In the cycle after an edge where `parent_active` was low, every bit of `child_en` is low.
- R7: `winner_changed` is high for exactly one cycle after an accepted step whose winner differs from the previous winner, or after the first accepted step following reset. It is low in all other cycles.
- R8: After reset, `winner_idx` is 0, `child_en` is all zeros and `winner_changed` is low. `child_en` stays all zeros until the first accepted step, even if `parent_active` is high.
- R9: When `NEURONS` is not a power of two, the selector never reports an index of `NEURONS` or above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_done | input | 1 | Strobe: the neuron array finished a step |
| parent_active | input | 1 | Activation of the parent chunk itself |
| activity | input | NEURONS*ACT_W | Packed unsigned activities, neuron i at bits [i*ACT_W +: ACT_W] |
| winner_idx | output | IDX_W | Registered index of the current winner |
| child_en | output | NEURONS | One-hot activation / clock-gate enable lines, bit i for the child of neuron i |
| winner_changed | output | 1 | One-cycle pulse when the winner moved |

## Verification
Every output is one register stage from its cause. `winner_idx`, `child_en` and `winner_changed` all take their new values at the clock edge that accepts a step. A fall of `parent_active` clears `child_en` at the next edge. The bench drives its stimulus on the falling edge and reads the outputs on the following falling edge, so each check lands in the first cycle the result is due. For the hold and ignore cases, the bench also checks in the cycles that follow. With five neurons of two bits each, the bench sweeps all 1024 activity patterns, computing the expected argmax, one-hot vector and change pulse arithmetically. It then tests idle cycles, a deactivated parent, a strobe that must be ignored, and reactivation.

// File: rtl/wsel_pkg.sv
package wsel_pkg;

    // Default sizing of one parent chunk
    localparam int unsigned DEF_NEURONS = 8;
    localparam int unsigned DEF_ACT_W   = 8;

    // Width of an index that addresses n neurons, at least one bit
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of comparator levels in the tournament for n entrants
    function automatic int unsigned tree_levels(input int unsigned n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction

endpackage

// File: rtl/wsel_argmax_tree.sv
// Combinational tournament: finds the largest activity, lowest index on ties.
module wsel_argmax_tree #(
    parameter int unsigned NEURONS = wsel_pkg::DEF_NEURONS,
    parameter int unsigned ACT_W   = wsel_pkg::DEF_ACT_W,
    parameter int unsigned IDX_W   = wsel_pkg::idx_width(NEURONS)
) (
    input  logic [NEURONS*ACT_W-1:0] activity,
    output logic [IDX_W-1:0]         best_idx
);
    localparam int unsigned LEVELS = wsel_pkg::tree_levels(NEURONS);
    localparam int unsigned LEAVES = 1 << LEVELS;
    localparam int unsigned NODES  = 2 * LEAVES;

    typedef struct packed {
        logic [ACT_W-1:0] val;
        logic [IDX_W-1:0] idx;
    } cand_t;

    // Heap layout: node 1 is the root, leaves sit at LEAVES .. 2*LEAVES-1.
    // The left child always covers lower indices than the right child.
    cand_t node [1:NODES-1];

    genvar gl;
    generate
        for (gl = 0; gl < LEAVES; gl++) begin : g_leaf
            if (gl < NEURONS) begin : g_real
                assign node[LEAVES+gl].val = activity[gl*ACT_W +: ACT_W];
                assign node[LEAVES+gl].idx = IDX_W'(gl);
            end else begin : g_pad
                // Padding lanes carry zero and a higher index than any
                // real lane, so with strict comparison they never win.
                assign node[LEAVES+gl].val = '0;
                assign node[LEAVES+gl].idx = IDX_W'(gl);
            end
        end
    endgenerate

    genvar gk;
    generate
        for (gk = 1; gk < LEAVES; gk++) begin : g_cmp
            // Right entrant takes the node only when strictly larger
            assign node[gk] = (node[2*gk+1].val > node[2*gk].val)
                              ? node[2*gk+1] : node[2*gk];
        end
    endgenerate

    assign best_idx = node[1].idx;

endmodule

// File: rtl/wsel_step_reg.sv
// Holds the winner between steps and produces the handover pulse.
module wsel_step_reg #(
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_done,
    input  logic             parent_active,
    input  logic [IDX_W-1:0] cand_idx,
    output logic [IDX_W-1:0] winner_idx,
    output logic             winner_changed,
    output logic [IDX_W-1:0] idx_next,
    output logic             valid_next
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } win_t;

    win_t cur_q;
    win_t cur_d;
    logic accept;
    logic moved;
    logic changed_q;

    assign accept = step_done & parent_active;
    assign moved  = accept & (~cur_q.valid | (cand_idx != cur_q.idx));

    always_comb begin
        cur_d = cur_q;
        if (accept) begin
            cur_d.valid = 1'b1;
            cur_d.idx   = cand_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            changed_q <= 1'b0;
        end else begin
            cur_q     <= cur_d;
            changed_q <= moved;
        end
    end

    assign winner_idx     = cur_q.idx;
    assign winner_changed = changed_q;
    assign idx_next       = cur_d.idx;
    assign valid_next     = cur_d.valid;

endmodule

// File: rtl/wsel_act_decode.sv
// Registered one-hot activation lines, one per child chunk.
module wsel_act_decode #(
    parameter int unsigned NEURONS = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               parent_active,
    input  logic               valid_next,
    input  logic [IDX_W-1:0]   idx_next,
    output logic [NEURONS-1:0] child_en
);
    logic               gate_open;
    logic [NEURONS-1:0] en_q;

    assign gate_open = parent_active & valid_next;

    genvar gi;
    generate
        for (gi = 0; gi < NEURONS; gi++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    en_q[gi] <= 1'b0;
                end else begin
                    en_q[gi] <= gate_open && (idx_next == IDX_W'(gi));
                end
            end
        end
    endgenerate

    assign child_en = en_q;

endmodule

// File: rtl/wsel_top.sv
module wsel_top #(
    parameter int unsigned NEURONS = wsel_pkg::DEF_NEURONS,
    parameter int unsigned ACT_W   = wsel_pkg::DEF_ACT_W,
    parameter int unsigned IDX_W   = wsel_pkg::idx_width(NEURONS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step_done,
    input  logic                     parent_active,
    input  logic [NEURONS*ACT_W-1:0] activity,
    output logic [IDX_W-1:0]         winner_idx,
    output logic [NEURONS-1:0]       child_en,
    output logic                     winner_changed
);
    logic [IDX_W-1:0] cand_idx;
    logic [IDX_W-1:0] idx_next;
    logic             valid_next;

    wsel_argmax_tree #(
        .NEURONS (NEURONS),
        .ACT_W   (ACT_W),
        .IDX_W   (IDX_W)
    ) tree_i (
        .activity (activity),
        .best_idx (cand_idx)
    );

    wsel_step_reg #(
        .IDX_W (IDX_W)
    ) step_i (
        .clk            (clk),
        .rst            (rst),
        .step_done      (step_done),
        .parent_active  (parent_active),
        .cand_idx       (cand_idx),
        .winner_idx     (winner_idx),
        .winner_changed (winner_changed),
        .idx_next       (idx_next),
        .valid_next     (valid_next)
    );

    wsel_act_decode #(
        .NEURONS (NEURONS),
        .IDX_W   (IDX_W)
    ) dec_i (
        .clk           (clk),
        .rst           (rst),
        .parent_active (parent_active),
        .valid_next    (valid_next),
        .idx_next      (idx_next),
        .child_en      (child_en)
    );

endmodule

// File: rtl/wsel_checker.sv
module wsel_checker #(
    parameter int unsigned NEURONS = 8,
    parameter int unsigned ACT_W   = 8,
    parameter int unsigned IDX_W   = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     step_done,
    input logic                     parent_active,
    input logic [NEURONS*ACT_W-1:0] activity,
    input logic [IDX_W-1:0]         winner_idx,
    input logic [NEURONS-1:0]       child_en,
    input logic                     winner_changed
);
    // Copy of the activities seen at the last accepted step
    logic [NEURONS*ACT_W-1:0] act_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (step_done && parent_active) begin
            act_q <= activity;
        end
    end

    logic max_ok;
    always_comb begin
        max_ok = (int'(winner_idx) < NEURONS);
        if (max_ok) begin
            for (int i = 0; i < NEURONS; i++) begin
                if (i < int'(winner_idx)) begin
                    if (act_q[i*ACT_W +: ACT_W] >= act_q[int'(winner_idx)*ACT_W +: ACT_W])
                        max_ok = 1'b0;
                end else begin
                    if (act_q[i*ACT_W +: ACT_W] > act_q[int'(winner_idx)*ACT_W +: ACT_W])
                        max_ok = 1'b0;
                end
            end
        end
    end

    // R1 and R2: strict maximum before the winner, no larger one after it
    assert_argmax_R1: assert property (@(posedge clk) disable iff (rst)
        (step_done && parent_active) |=> max_ok);

    // R9
    assert_idx_range_R9: assert property (@(posedge clk) disable iff (rst)
        int'(winner_idx) < NEURONS);

    // R3 and R4
    assert_idx_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(step_done && parent_active) |=> $stable(winner_idx));

    // R5
    assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(child_en));

    assert_line_matches_R5: assert property (@(posedge clk) disable iff (rst)
        (child_en != '0) |-> child_en[winner_idx]);

    // R6
    assert_parent_off_R6: assert property (@(posedge clk) disable iff (rst)
        !parent_active |=> (child_en == '0));

    // R7 and R4
    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (rst)
        winner_changed |-> $past(step_done && parent_active));

endmodule

bind wsel_top wsel_checker #(
    .NEURONS (NEURONS),
    .ACT_W   (ACT_W),
    .IDX_W   (IDX_W)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .step_done      (step_done),
    .parent_active  (parent_active),
    .activity       (activity),
    .winner_idx     (winner_idx),
    .child_en       (child_en),
    .winner_changed (winner_changed)
);

// File: tb/wsel_tb_top.sv
module wsel_top_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned N          = 5;
    localparam int unsigned AW         = 2;
    localparam int unsigned IW         = 3;
    localparam int unsigned PATTERNS   = 1 << (N * AW);
    localparam int unsigned WD_CYCLES  = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              step_done;
    logic              parent_active;
    logic [N*AW-1:0]   activity;
    logic [IW-1:0]     winner_idx;
    logic [N-1:0]      child_en;
    logic              winner_changed;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    int  m_idx   = 0;
    bit  m_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wsel_top #(
        .NEURONS (N),
        .ACT_W   (AW)
    ) dut_i (
        .clk            (clk),
        .rst            (rst),
        .step_done      (step_done),
        .parent_active  (parent_active),
        .activity       (activity),
        .winner_idx     (winner_idx),
        .child_en       (child_en),
        .winner_changed (winner_changed)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    function automatic int ref_max(input logic [N*AW-1:0] a);
        int best = 0;
        for (int i = 1; i < N; i++)
            if (a[i*AW +: AW] > a[best*AW +: AW]) best = i;
        return best;
    endfunction

    function automatic bit has_tie(input logic [N*AW-1:0] a, input int w);
        for (int i = 0; i < N; i++)
            if (i != w && a[i*AW +: AW] == a[w*AW +: AW]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        rst           = 1'b1;
        step_done     = 1'b0;
        parent_active = 1'b1;
        activity      = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state, lines low although parent is active
        check("R8 idx", int'(winner_idx), 0);
        check("R8 en", int'(child_en), 0);
        check("R8 pulse", int'(winner_changed), 0);
        @(negedge clk);
        check("R8 en before first step", int'(child_en), 0);

        // Exhaustive sweep of all activity patterns, parent active
        for (int v = 0; v < PATTERNS; v++) begin
            int  w;
            bit  exp_chg;
            activity  = (N*AW)'(v);
            step_done = 1'b1;
            w         = ref_max(activity);
            exp_chg   = !m_valid || (w != m_idx);
            m_idx     = w;
            m_valid   = 1'b1;
            @(negedge clk);
            step_done = 1'b0;
            if (has_tie(activity, w))
                check("R2 tie idx", int'(winner_idx), w);
            else
                check("R1 idx", int'(winner_idx), w);
            check("R9 range", int'(int'(winner_idx) < N), 1);
            check("R5 en", int'(child_en), 1 << w);
            check("R7 pulse", int'(winner_changed), int'(exp_chg));
        end

        // R3 and R7: idle cycles with a new pattern present
        activity = '0;
        activity[(N-1)*AW +: AW] = '1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R3 hold idx", int'(winner_idx), m_idx);
            check("R7 no pulse idle", int'(winner_changed), 0);
            check("R5 en idle", int'(child_en), 1 << m_idx);
        end

        // R6: parent drops
        parent_active = 1'b0;
        @(negedge clk);
        check("R6 en off", int'(child_en), 0);
        // R4: strobe while parent is inactive selects a new neuron otherwise
        activity = '0;
        activity[((m_idx == 0) ? 1 : 0)*AW +: AW] = '1;
        step_done = 1'b1;
        @(negedge clk);
        step_done = 1'b0;
        check("R4 idx kept", int'(winner_idx), m_idx);
        check("R4 no pulse", int'(winner_changed), 0);
        check("R6 en still off", int'(child_en), 0);
        @(negedge clk);
        check("R4 idx kept later", int'(winner_idx), m_idx);
        check("R4 no pulse later", int'(winner_changed), 0);

        // R5: reactivation restores the old winner's line without a step
        parent_active = 1'b1;
        @(negedge clk);
        check("R5 en restored", int'(child_en), 1 << m_idx);
        check("R7 no pulse on reactivation", int'(winner_changed), 0);

        // Same winner twice: no pulse (R7)
        activity  = '0;
        activity[m_idx*AW +: AW] = '1;
        step_done = 1'b1;
        @(negedge clk);
        step_done = 1'b0;
        check("R7 same winner no pulse", int'(winner_changed), 0);
        check("R1 same winner idx", int'(winner_idx), m_idx);

        done = 1'b1;
        summary();
    end

endmodule